// File: doc/BRIEF.md
# Coherence Miss Classifier

This block observes the memory accesses that a group of processors (two by default) make to a small set of multi-word cache blocks. It classifies every access as a hit, a cold miss, a true-sharing miss or a false-sharing miss. It keeps one shadow copy state per block and per processor and applies an invalidation protocol to those copies: a write by one processor removes every other processor's copy of the whole block.

Every copy that has been invalidated keeps a bitmask of the words that other processors have written since the invalidation. A later miss on that copy counts as true sharing when the word being touched is in the mask, because new data actually moves. It counts as false sharing when the copy was lost only through writes to other words, which is a miss that a one-word block would not have taken.

A write to a block that another processor still holds is an upgrade. The first write ever made to a block counts as a true-sharing event, and later upgrades count as false sharing. The block accepts one access per cycle and returns its verdict one cycle later. No data values or memory timing are modelled.

Top module: `coherence_miss_classifier`

## Requirements
- R1: After reset `res_valid` is low, and the first access by any processor to any block is reported as a cold miss.
- R2: An access by a processor to a block it has never held gets code 2'b11 (cold). From then on that copy is counted as held.
- R3: Code 2'b00 (hit) is reported in two cases: a read to a valid copy, and a write to a valid copy that no other processor holds valid.
- R4: A write by one processor to a block invalidates every other processor's valid copy of that block. The next access by such a processor to that block is a miss.
- R5: A miss on an invalidated copy gets code 2'b01 (true sharing) when the accessed word was written by another processor after the invalidation.
- R6: A miss on an invalidated copy gets code 2'b10 (false sharing) when none of the writes since the invalidation touched the accessed word.
- R7: A write to a valid copy while another processor also holds the block valid is classified as follows:
  - 2'b01 if no write has ever been made to that block.
  - 2'b10 otherwise.
- R8: After any miss, the requesting copy is valid with an empty written-word mask. An immediate read by the same processor to the same block is a hit.
- R9: `res_valid` goes high exactly in the cycle after a cycle with `acc_valid` high. `res_code` is meaningful only while `res_valid` is high.
- R10: While a copy stays invalid, writes by other processors to several different words accumulate in its mask. A later miss on any of those words is true sharing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_pid | input | PID_W | Requesting processor number |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_block | input | BLK_W | Block index |
| acc_word | input | WRD_W | Word index within the block |
| res_valid | output | 1 | Classification strobe, one cycle after the access |
| res_code | output | 2 | 00 hit, 01 true sharing, 10 false sharing, 11 cold |

## Verification
The bench replays a two-processor sequence in which both processors hold one block and then alternate writes and reads to two different words of it. A design that ignored the word index would report every one of those misses as true sharing. A design that did not track first writes would score the repeated upgrade write the same way as the first one.

A separate case lets several writes land on a copy that is already invalid and then reads the earlier word. A design that overwrote the mask instead of accumulating it would call that read false sharing. Back-to-back accesses with idle gaps between them check the strobe and the refill. A design that kept the old mask after a refill, or took a full cycle to update a copy, would misreport the access that follows.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
   typedef enum logic [1:0] {
      CLS_HIT   = 2'b00,
      CLS_TRUE  = 2'b01,
      CLS_FALSE = 2'b10,
      CLS_COLD  = 2'b11
   } cls_code_e;
endpackage

// File: rtl/cmc_copy_state.sv
module cmc_copy_state #(
   parameter int NWORD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             self_acc,
   input  logic             other_wr,
   input  logic [NWORD-1:0] word_oh,
   output logic             valid_o,
   output logic             held_o,
   output logic [NWORD-1:0] mask_o
);
   logic             valid_q, held_q;
   logic [NWORD-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         held_q  <= 1'b0;
         mask_q  <= '0;
      end else if (self_acc && !valid_q) begin
         valid_q <= 1'b1;
         held_q  <= 1'b1;
         mask_q  <= '0;
      end else if (other_wr) begin
         if (valid_q) begin
            valid_q <= 1'b0;
            mask_q  <= word_oh;
         end else if (held_q) begin
            mask_q  <= mask_q | word_oh;
         end
      end
   end

   assign valid_o = valid_q;
   assign held_o  = held_q;
   assign mask_o  = mask_q;

   p_invalidate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (other_wr && !self_acc) |=> !valid_q);
   p_refill_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (self_acc && !valid_q) |=> (valid_q && mask_q == '0));
   p_held_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      held_q |=> held_q);
   p_mask_grows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (other_wr && !self_acc && !valid_q && held_q) |=>
         (((mask_q & $past(mask_q)) == $past(mask_q)) &&
          ((mask_q & $past(word_oh)) == $past(word_oh))));
endmodule

// File: rtl/cmc_classify.sv
module cmc_classify
   import cmc_pkg::*;
(
   input  logic      req_valid,
   input  logic      req_held,
   input  logic      req_mask_bit,
   input  logic      others_valid,
   input  logic      is_write,
   input  logic      blk_written,
   output cls_code_e code
);
   always_comb begin
      if (!req_held)
         code = CLS_COLD;
      else if (!req_valid)
         code = req_mask_bit ? CLS_TRUE : CLS_FALSE;
      else if (is_write && others_valid)
         code = blk_written ? CLS_FALSE : CLS_TRUE;
      else
         code = CLS_HIT;
   end
endmodule

// File: rtl/coherence_miss_classifier.sv
module coherence_miss_classifier
   import cmc_pkg::*;
#(
   parameter  int NPROC = 2,
   parameter  int NBLK  = 8,
   parameter  int NWORD = 4,
   localparam int PID_W = (NPROC > 1) ? $clog2(NPROC) : 1,
   localparam int BLK_W = (NBLK  > 1) ? $clog2(NBLK)  : 1,
   localparam int WRD_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [PID_W-1:0] acc_pid,
   input  logic             acc_write,
   input  logic [BLK_W-1:0] acc_block,
   input  logic [WRD_W-1:0] acc_word,
   output logic             res_valid,
   output logic [1:0]       res_code
);
   if (NPROC < 2 || (1 << PID_W) != NPROC) begin : g_bad_proc
      $error("NPROC must be a power of two and at least 2");
   end
   if (NBLK < 2 || (1 << BLK_W) != NBLK) begin : g_bad_blk
      $error("NBLK must be a power of two and at least 2");
   end
   if (NWORD < 2 || (1 << WRD_W) != NWORD) begin : g_bad_word
      $error("NWORD must be a power of two and at least 2");
   end

   logic [NWORD-1:0] word_oh;
   logic [NPROC-1:0] cp_valid [NBLK];
   logic [NPROC-1:0] cp_held  [NBLK];
   logic [NWORD-1:0] cp_mask  [NBLK][NPROC];
   logic [NBLK-1:0]  blk_written_q;

   assign word_oh = NWORD'(1) << acc_word;

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      for (genvar p = 0; p < NPROC; p++) begin : g_proc
         cmc_copy_state #(.NWORD(NWORD)) u_copy (
            .clk      (clk),
            .rst_n    (rst_n),
            .self_acc (acc_valid && acc_block == BLK_W'(b) && acc_pid == PID_W'(p)),
            .other_wr (acc_valid && acc_write && acc_block == BLK_W'(b) &&
                       acc_pid != PID_W'(p)),
            .word_oh  (word_oh),
            .valid_o  (cp_valid[b][p]),
            .held_o   (cp_held[b][p]),
            .mask_o   (cp_mask[b][p])
         );
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         blk_written_q <= '0;
      else if (acc_valid && acc_write)
         blk_written_q[acc_block] <= 1'b1;
   end

   logic             req_valid, req_held, req_mask_bit, others_valid;
   logic [NWORD-1:0] req_mask;

   always_comb begin
      req_valid    = cp_valid[acc_block][acc_pid];
      req_held     = cp_held[acc_block][acc_pid];
      req_mask     = cp_mask[acc_block][acc_pid];
      req_mask_bit = req_mask[acc_word];
      others_valid = 1'b0;
      for (int p = 0; p < NPROC; p++) begin
         if (PID_W'(p) != acc_pid)
            others_valid = others_valid | cp_valid[acc_block][p];
      end
   end

   cls_code_e cls_now;

   cmc_classify u_cls (
      .req_valid    (req_valid),
      .req_held     (req_held),
      .req_mask_bit (req_mask_bit),
      .others_valid (others_valid),
      .is_write     (acc_write),
      .blk_written  (blk_written_q[acc_block]),
      .code         (cls_now)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_code  <= 2'b00;
      end else begin
         res_valid <= acc_valid;
         if (acc_valid)
            res_code <= cls_now;
      end
   end

   p_strobe_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> res_valid);
   p_strobe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !res_valid);
   p_write_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write) |=> blk_written_q[$past(acc_block)]);
endmodule

// File: tb/coherence_miss_classifier_bench.sv
module coherence_miss_classifier_bench;
   localparam int NPROC = 2, NBLK = 8, NWORD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [0:0] acc_pid = '0;
   logic       acc_write = 1'b0;
   logic [2:0] acc_block = '0;
   logic [1:0] acc_word = '0;
   logic       res_valid;
   logic [1:0] res_code;

   always #5 clk = ~clk;

   coherence_miss_classifier #(.NPROC(NPROC), .NBLK(NBLK), .NWORD(NWORD))
   u_coherence_miss_classifier (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pid(acc_pid),
      .acc_write(acc_write), .acc_block(acc_block), .acc_word(acc_word),
      .res_valid(res_valid), .res_code(res_code));

   int checks = 0, fails = 0;
   bit done = 0;

   // Behavioural reference state
   bit rv [NBLK][NPROC];
   bit rh [NBLK][NPROC];
   int rm [NBLK][NPROC];
   bit rw [NBLK];

   bit    pend_v = 0;
   int    pend_code = 0;
   string pend_tag = "";

   task automatic check(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   function automatic string tag_of(int code);
      case (code)
         0: return "R3";
         1: return "R5";
         2: return "R6";
         default: return "R2";
      endcase
   endfunction

   task automatic step(bit v, int pid, bit wr, int blk, int wd, string tag);
      int code;
      bit oth;
      @(negedge clk);
      check("R9", int'(res_valid), int'(pend_v));
      if (pend_v && res_valid) check(pend_tag, int'(res_code), pend_code);
      acc_valid = v; acc_pid = 1'(pid); acc_write = wr;
      acc_block = 3'(blk); acc_word = 2'(wd);
      pend_v = v;
      if (!v) return;
      oth = 0;
      for (int q = 0; q < NPROC; q++) if (q != pid && rv[blk][q]) oth = 1;
      if (!rh[blk][pid]) code = 3;
      else if (!rv[blk][pid]) code = rm[blk][pid][wd] ? 1 : 2;
      else if (wr && oth) code = rw[blk] ? 2 : 1;
      else code = 0;
      if (!rv[blk][pid]) begin
         rv[blk][pid] = 1; rh[blk][pid] = 1; rm[blk][pid] = 0;
      end
      if (wr) begin
         for (int q = 0; q < NPROC; q++) begin
            if (q == pid) continue;
            if (rv[blk][q]) begin rv[blk][q] = 0; rm[blk][q] = 1 << wd; end
            else if (rh[blk][q]) rm[blk][q] |= (1 << wd);
         end
         rw[blk] = 1;
      end
      pend_code = code;
      pend_tag = (tag != "") ? tag : tag_of(code);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < NBLK; b++) begin
         rw[b] = 0;
         for (int p = 0; p < NPROC; p++) begin rv[b][p] = 0; rh[b][p] = 0; rm[b][p] = 0; end
      end
      repeat (3) @(negedge clk);
      check("R1", int'(res_valid), 0);
      rst_n = 1'b1;
      // R1/R2: first touches are cold
      step(1, 0, 0, 3, 0, "R1");
      step(1, 0, 0, 3, 1, "R3");
      step(1, 1, 0, 3, 0, "R2");
      step(1, 1, 0, 3, 1, "R3");
      // shared-block scenario, x1 = word 0, x2 = word 1
      step(1, 0, 1, 3, 0, "R7");  // first write: true
      step(1, 1, 0, 3, 1, "R6");  // false
      step(1, 0, 1, 3, 0, "R7");  // repeat upgrade: false
      step(1, 1, 1, 3, 1, "R6");  // false, invalidates P0 (R4)
      step(1, 0, 0, 3, 1, "R5");  // true
      step(1, 0, 0, 3, 1, "R8");  // hit after refill
      step(0, 0, 0, 0, 0, "");
      // R10: accumulation while invalid
      step(1, 0, 0, 5, 2, "R2");
      step(1, 1, 0, 5, 2, "R2");
      step(1, 1, 1, 5, 2, "R7");
      step(1, 1, 1, 5, 3, "R3");
      step(1, 1, 1, 5, 0, "R3");
      step(1, 0, 0, 5, 2, "R10");
      step(1, 0, 0, 5, 1, "R8");
      step(1, 0, 1, 5, 1, "R4");
      step(1, 1, 0, 5, 1, "R4");
      // mixed stream
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 8) != 0, int'($urandom % NPROC), ($urandom % 3) == 0,
              int'($urandom % NBLK), int'($urandom % NWORD), "");
      end
      step(0, 0, 0, 0, 0, "");
      step(0, 0, 0, 0, 0, "");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule